// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

This block merges sixteen external interrupt sources into a single active-high level interrupt for a host processor. Every source passes through a two-flop synchronizer. A rising edge on the synchronized line latches a pending bit. The host interrupt stays high for as long as any pending bit is also enabled.

The host uses a small synchronous register bus with a byte address, a write strobe, write data and registered read data. The pending register is cleared bit by bit: writing a 1 to a bit clears it. The enable mask has two addresses of its own, one that turns bits on and one that turns bits off, so the host never needs a read-modify-write to change a single line. A further read-only view shows the synchronized input levels.

Top module: `irqagg_top`

## Requirements
- R1: While reset is asserted and directly after release, every pending bit and every enable bit is 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: A 0-to-1 change on `src_i[i]` sets pending bit i on the third rising clock edge after the change, whether or not line i is enabled.
- R3: Writing to offset 0x16 clears each pending bit whose write-data bit is 1 and leaves the other pending bits unchanged. A read of 0x16 returns the pending bits, with bit i belonging to line i.
- R4: If a new rising edge and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R5: A read of offset 0x18 returns the synchronized input levels, which lag `src_i` by two clock edges.
- R6: Writing to offset 0x1A sets each enable bit whose write-data bit is 1, and write-data bits of 0 leave their enable bits unchanged. A read of 0x1A returns the enable mask.
- R7: Writing to offset 0x1C clears each enable bit whose write-data bit is 1, and write-data bits of 0 leave their enable bits unchanged. A read of 0x1C also returns the enable mask. Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with the inputs steady, leaves every line disabled and nothing pending.
- R8: `irq_o` is high exactly when some bit is both pending and enabled.
- R9: Reads of any offset other than 0x16, 0x18, 0x1A and 0x1C return 0. Writes to such offsets, and writes to 0x18, change no state.
- R10: `bus_rdata` shows the register selected by the address sampled at the previous clock edge. A write takes effect at the edge where `bus_we` is sampled high.
- R11: An input held high sets its pending bit only once. After that bit is cleared it stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | LINES | Asynchronous interrupt source lines |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Registered read data |
| irq_o | output | 1 | Combined active-high level interrupt |

## Verification
A wrong pending or mask bit shows up on `irq_o` in the same cycle, because the output is a plain gate over the two registers. The same bit can also be read back on `bus_rdata` one cycle after its offset is presented. An edge detector that drops an edge, or fires again on a held level, shows up as a pending bit that differs from the model three edges after the input change. Every cycle, the bench compares both outputs against a cycle-level model built from the requirements, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  // Register byte offsets; the host driver depends on these values.
  localparam logic [7:0] OFS_PEND  = 8'h16;
  localparam logic [7:0] OFS_LIVE  = 8'h18;
  localparam logic [7:0] OFS_ENSET = 8'h1A;
  localparam logic [7:0] OFS_ENCLR = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_LIVE,
    SEL_MASK
  } rd_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] last_q;
  logic [W-1:0] rise_v;
  logic [W-1:0] pend_n;
  logic [W-1:0] clr_v;

  always_comb begin
    rise_v = level_i & ~last_q;
    clr_v  = clr_we ? clr_bits : '0;
    // a fresh edge overrides a simultaneous clear
    pend_n = (pend_q & ~clr_v) | rise_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      pend_q <= '0;
    end else begin
      last_q <= level_i;
      pend_q <= pend_n;
    end
  end

  // R4
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_v != '0) |=> ((pend_q & $past(rise_v)) == $past(rise_v)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_bits & ~rise_v) != '0)) |=>
      ((pend_q & $past(clr_bits & ~rise_v)) == '0));

  // R11
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(level_i) && !clr_we) |=> $stable(pend_q));
endmodule

// File: rtl/irqagg_enmask.sv
module irqagg_enmask #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_q
);
  logic         mask_en;
  logic [W-1:0] mask_n;

  always_comb begin
    mask_en = set_we | clr_we;
    mask_n  = mask_q;
    if (set_we) mask_n = mask_q | bits_i;
    else if (clr_we) mask_n = mask_q & ~bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_en) mask_q <= mask_n;
  end

  // R6
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(bits_i)) == $past(bits_i)));

  // R7
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(bits_i)) == '0));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  output logic              irq_o
);
  import irqagg_pkg::*;

  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFS_LIVE);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);

  logic [LINES-1:0] live_v;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] rd_n;
  logic [LINES-1:0] rd_q;
  logic             addr_hit;
  rd_sel_e          sel;

  always_comb begin
    unique case (bus_addr)
      A_PEND:           sel = SEL_PEND;
      A_LIVE:           sel = SEL_LIVE;
      A_ENSET, A_ENCLR: sel = SEL_MASK;
      default:          sel = SEL_NONE;
    endcase
    addr_hit = (sel != SEL_NONE);
  end

  irqagg_sync #(.W(LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .sync_o  (live_v)
  );

  irqagg_pending #(.W(LINES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (live_v),
    .clr_we   (bus_we && (bus_addr == A_PEND)),
    .clr_bits (bus_wdata),
    .pend_q   (pend_q)
  );

  irqagg_enmask #(.W(LINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (bus_we && (bus_addr == A_ENSET)),
    .clr_we (bus_we && (bus_addr == A_ENCLR)),
    .bits_i (bus_wdata),
    .mask_q (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND: rd_n = pend_q;
      SEL_LIVE: rd_n = live_v;
      SEL_MASK: rd_n = mask_q;
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_n;
  end

  assign bus_rdata = rd_q;
  assign irq_o     = |(pend_q & mask_q);

  // R8
  irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_q != '0) && (mask_q != '0)));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> (bus_rdata == '0));
endmodule

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
  localparam int L = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [L-1:0] src;
  logic [7:0]   addr;
  logic         wr_en;
  logic [L-1:0] wdata;
  logic [L-1:0] rdata;
  logic         irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [L-1:0] m_s1, m_s2, m_prev, m_pend, m_mask, m_rd;

  always #5 clk = ~clk;

  irqagg_top #(.LINES(L), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
    .bus_we(wr_en), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [L-1:0] rd_model(logic [7:0] a);
    case (a)
      8'h16:        return m_pend;
      8'h18:        return m_s2;
      8'h1A, 8'h1C: return m_mask;
      default:      return '0;
    endcase
  endfunction

  task automatic check(string req, logic [L-1:0] got, logic [L-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic bus(logic [7:0] a, logic we, logic [L-1:0] d);
    addr = a; wr_en = we; wdata = d;
  endtask

  // one clock: update the model from the inputs seen at the edge, then compare
  task automatic step(string req);
    logic [L-1:0] rise, clr, nrd;
    @(posedge clk);
    rise = m_s2 & ~m_prev;
    nrd  = rd_model(addr);
    clr  = '0;
    if (wr_en) begin
      if (addr == 8'h16) clr = wdata;
      if (addr == 8'h1A) m_mask = m_mask | wdata;
      if (addr == 8'h1C) m_mask = m_mask & ~wdata;
    end
    m_pend = (m_pend & ~clr) | rise;
    m_rd   = nrd;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = src;
    @(negedge clk);
    check(req, L'(irq), L'(|(m_pend & m_mask)));
    check(req, rdata, m_rd);
  endtask

  task automatic steps(int n, string req);
    for (int k = 0; k < n; k++) step(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog got=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    rst_n = 1'b0; src = '0; bus(8'h00, 1'b0, '0);
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    check("R1", L'(irq), '0);
    check("R1", rdata, '0);
    rst_n = 1'b1;
    step("R1");

    // R6: set bits 0 and 3, read back
    bus(8'h1A, 1'b1, 16'h0009); step("R6");
    bus(8'h1A, 1'b0, '0);       step("R6");
    check("R6", rdata, 16'h0009);

    // R2: rise on enabled line 0, three-edge latency
    bus(8'h00, 1'b0, '0);
    src = 16'h0001;
    steps(2, "R2");
    check("R2", L'(irq), '0);
    step("R2");
    check("R2", L'(irq), 16'h0001);

    // R2: disabled line 5 still latches
    src = 16'h0021;
    steps(3, "R2");
    bus(8'h16, 1'b0, '0); step("R2");
    check("R2", rdata, 16'h0021);

    // R5: live view
    bus(8'h18, 1'b0, '0); step("R5");
    check("R5", rdata, 16'h0021);

    // R3: clear bit 0 only, bit 5 stays
    bus(8'h16, 1'b1, 16'h0001); step("R3");
    check("R3", L'(irq), '0);
    bus(8'h16, 1'b0, '0); step("R3");
    check("R3", rdata, 16'h0020);

    // R11: held level does not re-set the cleared bit
    steps(3, "R11");
    check("R11", rdata, 16'h0020);

    // R4: edge and clear collide on bit 0
    bus(8'h00, 1'b0, '0);
    src = 16'h0020; steps(3, "R4");
    src = 16'h0021; steps(2, "R4");
    bus(8'h16, 1'b1, 16'h0001); step("R4");
    bus(8'h16, 1'b0, '0); step("R4");
    check("R4", rdata, 16'h0021);
    check("R4", L'(irq), 16'h0001);

    // R9: writes to read-only and unmapped offsets, unmapped reads
    bus(8'h18, 1'b1, 16'hFFFF); step("R9");
    bus(8'h00, 1'b1, 16'hFFFF); step("R9");
    bus(8'h16, 1'b0, '0); step("R9");
    check("R9", rdata, 16'h0021);
    bus(8'h00, 1'b0, '0); step("R9");
    check("R9", rdata, '0);
    bus(8'h17, 1'b0, '0); step("R9");
    check("R9", rdata, '0);
    bus(8'h1A, 1'b0, '0); step("R9");
    check("R9", rdata, 16'h0009);

    // R7: disable line 0
    bus(8'h1C, 1'b1, 16'h0001); step("R7");
    check("R7", L'(irq), '0);
    bus(8'h1C, 1'b0, '0); step("R7");
    check("R7", rdata, 16'h0008);

    // R10: read data follows the previously sampled address
    bus(8'h18, 1'b0, '0);
    #1 check("R10", rdata, 16'h0008);
    step("R10");
    check("R10", rdata, 16'h0021);

    // R7: full disable then full clear
    bus(8'h1C, 1'b1, 16'hFFFF); step("R7");
    bus(8'h16, 1'b1, 16'hFFFF); step("R7");
    bus(8'h1A, 1'b0, '0); step("R7");
    check("R7", rdata, '0);
    bus(8'h16, 1'b0, '0); step("R7");
    check("R7", rdata, '0);
    check("R8", L'(irq), '0);

    // R8: random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h16;
        1: a = 8'h18;
        2: a = 8'h1A;
        3: a = 8'h1C;
        4: a = 8'(2 * $urandom_range(0, 20));
        default: a = 8'h16;
      endcase
      if ($urandom_range(0, 3) == 0) src = src ^ L'($urandom) & L'($urandom) & L'($urandom);
      bus(a, ($urandom_range(0, 1) == 1), L'($urandom) & L'($urandom));
      step("R8");
    end

    bus(8'h00, 1'b0, '0);
    finish_run();
  end
endmodule